// File: doc/BRIEF.md
# Programmable Serial Transmitter with Baud Divisor

This block turns bytes written by a host into asynchronous serial frames. The host reaches it through a small register window selected by a 3-bit address. Through that window it sets the frame format, loads a 16-bit clock divisor, and pushes bytes into a 16-entry transmit queue. A divider built from the system clock produces a tick at sixteen times the bit rate. The framer takes one byte at a time from the queue and shifts it out on a single output line.

Each frame has a start bit, then 5 to 8 data bits, then an optional parity bit, then a stop period. The frame format is captured when a frame begins. A later change to the format therefore applies only to the next frame. A status register tells the host whether the queue can accept another byte and whether the line has gone fully quiet. A break control forces the line low while it is set.

Top module: `uart_tx_core`

## Requirements
- R1: After reset the line is high, the format register reads 0x00, the divisor is 0, and status (address 5) reads 0x60.
- R2: Address 3 writes and reads the format register. Its bits are: [1:0] word length, [2] stop select, [3] parity enable, [4] even, [5] stick, [6] break, [7] divisor access. While bit 7 is 1, addresses 0 and 1 write and read the divisor low and high bytes. While bit 7 is 0, a write to address 0 queues a byte and a write to address 1 has no effect.
- R3: A nonzero divisor N gives one tick every N clocks, and each bit time lasts 16 ticks. A divisor of 0 stops the ticks, and the line then holds its current level.
- R4: A frame starts with a 0 start bit. The data follows least significant bit first, with the length set by the word-length code: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8.
- R5: With parity enabled, the parity bit is set as follows. Even mode with stick off makes the count of ones even. Odd mode with stick off makes it odd. Stick with even clear sends 1. Stick with even set sends 0. With parity disabled, no parity bit is sent.
- R6: Stop is 16 ticks high when stop select is 0. When stop select is 1, stop is 24 ticks for 5-bit words and 32 ticks for longer words.
- R7: While the break bit is 1 the line reads 0. The frame timing continues underneath, and the line shows the frame again once break is cleared.
- R8: The queue holds 16 bytes and sends them in write order. A frame starts without an idle gap when the previous frame ends and a byte is waiting. A byte written while the queue is full is dropped.
- R9: Status bit 5 is 1 when the queue is not full. Status bit 6 is 1 when the queue is empty and no frame is in progress. All other status bits are 0.
- R10: The format in force when a frame starts governs that whole frame. This covers word length, parity and stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 3 | Register address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register (combinational) |
| tx_out | output | 1 | Serial line, idles high |

## Verification
A host write into the queue and the framer taking the head byte can land on the same clock edge. This happens most often when one stop period ends while the host is still streaming bytes, and at the moment the queue is full. The bench provokes this by streaming writes back-to-back through several frame boundaries and by overfilling the queue while a frame is finishing. It judges the result against a queue-based reference model. That model decides the fullness drop from the occupancy before the edge, so a lost, duplicated or reordered byte shows up on the line, and a wrong occupancy shows up in the status bits.

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int DEPTH = 16,
  parameter int DIVW  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       tx_out
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULLC = DEPTH[AW:0];

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [7:0]      lcr;
  logic [DIVW-1:0] dl, bcnt;
  logic [7:0]      mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [AW:0]     count;
  st_t             state;
  logic [4:0]      cnt5, stop_last;
  logic [7:0]      sh;
  logic [2:0]      bitn;
  logic [1:0]      f_len;
  logic            f_pen, f_par;

  wire dlab    = lcr[7];
  wire tick    = (dl != '0) && (bcnt >= dl - DIVW'(1));
  wire full    = (count == FULLC);
  wire empty   = (count == '0);
  wire fifo_wr = wr_en && sel == 3'd0 && !dlab;
  wire push    = fifo_wr && !full;
  wire fend    = state == S_STOP && tick && cnt5 == stop_last;
  wire pop     = tick && !empty && (state == S_IDLE || fend);
  wire temt    = empty && state == S_IDLE;

  wire [7:0] head = mem[rp];
  wire [7:0] mask = 8'hFF >> (2'd3 - lcr[1:0]);
  wire       peven = ^(head & mask);
  wire       pbit  = lcr[5] ? ~lcr[4] : (lcr[4] ? peven : ~peven);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr <= '0;
      dl  <= '0;
    end else if (wr_en) begin
      if (sel == 3'd3) lcr <= wdata;
      if (dlab && sel == 3'd0) dl[7:0] <= wdata;
      if (dlab && sel == 3'd1) dl[DIVW-1:8] <= wdata[DIVW-9:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tick || dl == '0) bcnt <= '0;
    else bcnt <= bcnt + DIVW'(1);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      if (push && !pop) count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt5 <= '0;
      sh <= '0;
      bitn <= '0;
      f_len <= '0;
      f_pen <= 1'b0;
      f_par <= 1'b0;
      stop_last <= 5'd15;
    end else if (pop) begin
      state <= S_START;
      cnt5 <= '0;
      sh <= head;
      f_len <= lcr[1:0];
      f_pen <= lcr[3];
      f_par <= pbit;
      stop_last <= !lcr[2] ? 5'd15 : (lcr[1:0] == 2'd0 ? 5'd23 : 5'd31);
    end else if (tick) begin
      cnt5 <= cnt5 + 5'd1;
      case (state)
        S_START: if (cnt5 == 5'd15) begin
          state <= S_DATA;
          cnt5 <= '0;
          bitn <= '0;
        end
        S_DATA: if (cnt5 == 5'd15) begin
          cnt5 <= '0;
          sh <= sh >> 1;
          if (bitn == 3'd4 + {1'b0, f_len}) state <= f_pen ? S_PAR : S_STOP;
          else bitn <= bitn + 3'd1;
        end
        S_PAR: if (cnt5 == 5'd15) begin
          state <= S_STOP;
          cnt5 <= '0;
        end
        S_STOP: if (cnt5 == stop_last) begin
          state <= S_IDLE;
          cnt5 <= '0;
        end
        default: cnt5 <= '0;
      endcase
    end
  end

  logic line;
  always_comb begin
    case (state)
      S_START: line = 1'b0;
      S_DATA:  line = sh[0];
      S_PAR:   line = f_par;
      default: line = 1'b1;
    endcase
  end
  assign tx_out = line && !lcr[6];

  always_comb begin
    case (sel)
      3'd0:    rdata = dlab ? dl[7:0] : 8'h00;
      3'd1:    rdata = dlab ? 8'(dl[DIVW-1:8]) : 8'h00;
      3'd3:    rdata = lcr;
      3'd5:    rdata = {1'b0, temt, !full, 5'b0};
      default: rdata = 8'h00;
    endcase
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n) count <= FULLC);
  p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && full && !pop) |=> full);
  p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dl == '0 && state != S_IDLE) |=> ($stable(state) && $stable(cnt5)));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (state == S_START && cnt5 == 5'd0));
  p_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_DATA |-> bitn <= 3'd4 + {1'b0, f_len});
  p_stop_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_STOP |-> cnt5 <= stop_last);
endmodule

// File: tb/sim_uart_tx_core.sv
`timescale 1ns/1ps
module sim_uart_tx_core;
  logic clk = 0, rst_n = 0, wr_en = 0, tx_out;
  logic [2:0] sel = 3'd5;
  logic [7:0] wdata = 0, rdata;
  int total = 0, bad = 0, cyc = 0;
  string tag = "R1";

  uart_tx_core u0 (.clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
                   .wdata(wdata), .rdata(rdata), .tx_out(tx_out));

  always #2.5 clk = ~clk;

  int q[$];
  int lvl[$];
  logic [7:0] m_lcr = 0;
  logic [15:0] m_div = 0;
  int bc = 0;

  task automatic build(input int d);
    int n = 5 + m_lcr[1:0];
    int ones = 0;
    int p;
    int st;
    repeat (16) lvl.push_back(0);
    for (int i = 0; i < n; i++) begin
      repeat (16) lvl.push_back((d >> i) & 1);
      ones += (d >> i) & 1;
    end
    if (m_lcr[3]) begin
      if (m_lcr[5]) p = m_lcr[4] ? 0 : 1;
      else p = m_lcr[4] ? (ones % 2) : 1 - (ones % 2);
      repeat (16) lvl.push_back(p);
    end
    st = !m_lcr[2] ? 16 : (n == 5 ? 24 : 32);
    repeat (st) lvl.push_back(1);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); lvl.delete(); m_lcr = 0; m_div = 0; bc = 0;
    end else begin
      bit tk, full_pre;
      full_pre = (q.size() == 16);
      tk = 0;
      if (m_div == 0) bc = 0;
      else if (bc >= m_div - 1) begin tk = 1; bc = 0; end
      else bc++;
      if (tk) begin
        if (lvl.size() > 0) void'(lvl.pop_front());
        if (lvl.size() == 0 && q.size() > 0) build(q.pop_front());
      end
      if (wr_en) begin
        case (sel)
          3'd0: if (m_lcr[7]) m_div[7:0] = wdata; else if (!full_pre) q.push_back(wdata);
          3'd1: if (m_lcr[7]) m_div[15:8] = wdata;
          3'd3: m_lcr = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", r, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    if (rst_n) begin
      chk(tag, tx_out, m_lcr[6] ? 0 : (lvl.size() ? lvl[0] : 1));
      if (sel == 3'd5 && !wr_en)
        chk({tag, " R9 status"}, rdata,
            {1'b0, (q.size() == 0 && lvl.size() == 0), (q.size() < 16), 5'b0});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); sel = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; sel = 3'd5;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string r);
    @(negedge clk); sel = a;
    @(posedge clk); #1.5;
    chk(r, rdata, e);
    @(negedge clk); sel = 3'd5;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 60000 && (q.size() || lvl.size()); k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] f, input int d);
    wr(3'd3, f); wr(3'd0, d[7:0]);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 line", tx_out, 1);
    rd(3'd3, 8'h00, "R1 format");
    rd(3'd5, 8'h60, "R1 status");
    wr(3'd3, 8'h80);
    rd(3'd0, 8'h00, "R1 divisor");
    tag = "R2";
    wr(3'd0, 8'h02); wr(3'd1, 8'h01);
    rd(3'd0, 8'h02, "R2 div low");
    rd(3'd1, 8'h01, "R2 div high");
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h03);
    rd(3'd3, 8'h03, "R2 format");
    wr(3'd1, 8'hAB);
    wr(3'd3, 8'h83);
    rd(3'd1, 8'h00, "R2 ignored addr1");
    rd(3'd0, 8'h02, "R2 div kept");
    wr(3'd3, 8'h03);
    chk("R2 line idle", tx_out, 1);

    tag = "R4 R8 8N1";
    wr(3'd0, 8'hA5); wr(3'd0, 8'h3C); wr(3'd0, 8'h01);
    wait_idle();
    tag = "R5 R6 5E2";  send(8'h1C, 8'h13); wait_idle();
    tag = "R5 R6 7O2";  send(8'h0E, 8'h55); wait_idle();
    tag = "R5 stick0";  send(8'h3B, 8'hFF); wait_idle();
    tag = "R5 stick1";  send(8'h2B, 8'h00); wait_idle();
    tag = "R4 6N1";     send(8'h01, 8'h2D); wait_idle();
    tag = "R5 R6 6E2";  send(8'h1D, 8'h07); wait_idle();

    tag = "R8 overfill";
    wr(3'd3, 8'h03);
    for (int i = 0; i < 18; i++) wr(3'd0, 8'(i * 13 + 1));
    rd(3'd5, 8'h00, "R8 R9 full status");
    for (int i = 0; i < 6; i++) begin
      repeat (150) @(negedge clk);
      wr(3'd0, 8'(8'hC0 + i));
    end

    tag = "R10 latch";
    repeat (100) @(negedge clk);
    wr(3'd3, 8'h0C);
    repeat (500) @(negedge clk);
    wr(3'd3, 8'h03);
    wait_idle();

    tag = "R7 break";
    wr(3'd0, 8'h96);
    repeat (60) @(negedge clk);
    wr(3'd3, 8'h43);
    chk("R7 forced low", tx_out, 0);
    repeat (90) @(negedge clk);
    wr(3'd3, 8'h03);
    wait_idle();

    tag = "R3 halt";
    wr(3'd0, 8'h5A);
    repeat (80) @(negedge clk);
    wr(3'd3, 8'h83); wr(3'd0, 8'h00);
    repeat (200) @(negedge clk);
    wr(3'd0, 8'h03); wr(3'd3, 8'h03);
    tag = "R3 div3";
    wr(3'd0, 8'hE7);
    wait_idle();
    chk("R1 R9 final idle", tx_out, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule